// File: doc/BRIEF.md
# Memory Tag Check Unit

This block sits between a load/store requester and a small on-chip data memory and enforces memory tagging. The memory is split into 16-byte aligned granules, and each granule holds a 4-bit allocation tag in a separate tag store. Every request carries a 64-bit pointer. Bits [59:56] of the pointer hold the logical tag. The whole top byte is dropped when the physical address for data and tag lookup is formed. On each accepted read or write, the logical tag is compared with the allocation tag of the addressed granule.

A 2-bit check mode decides what a mismatch does:
- Synchronous mode blocks the access and reports a fault with a status code.
- Asynchronous mode lets the access complete and raises a sticky fault flag.
- Asymmetric mode treats reads synchronously and writes asynchronously.
- Mode 00 turns checking off.

A separate tag-fill command paints one tag over a byte range, widened outward to whole granules, at one granule per cycle. Requests stall while a fill is running.

Top module: `mem_tag_guard`

## Requirements
- R1: After reset the mode is 00, `tag_flag` is 0, `rsp_valid` and `rsp_fault` are 0, `req_ready` is 1, and every granule's allocation tag is 0.
- R2: In mode 00 no access ever faults: writes are committed and reads return the stored word, whatever the logical tag.
- R3: The logical tag is pointer bits [59:56]. Pointer bits [63:MEM_AW] are ignored for addressing. Bits [3:0] pick a byte inside a granule and do not affect which tag is looked up.
- R4: A synchronous mismatch blocks the access: a write leaves memory unchanged and a read returns 0. `rsp_fault` is 1, `rsp_status` is 6'b010001 and `rsp_fnv` is 0. `tag_flag` is not set by it.
- R5: In mode 10, a mismatching access completes normally (read data returned, write data committed) and `tag_flag` is set.
- R6: In mode 11, a mismatching read behaves as in R4 and a mismatching write behaves as in R5. In mode 01 both directions behave as in R4.
- R7: `tag_flag` stays set until a `flag_clr` pulse. An access that sets the flag in the same cycle as a clear leaves it set.
- R8: A `cfg_we` pulse loads `cfg_mode` and clears `tag_flag`. The new mode applies to requests from the next cycle.
- R9: A fill writes `tcmd_tag` into every granule from floor(addr/16) up to, but not including, ceil((addr+len)/16). It writes one granule per cycle. `req_ready` is 0 for exactly that many cycles, and a fill whose range rounds to zero granules writes nothing.
- R10: A request accepted in one cycle (`req_valid` and `req_ready`) produces exactly one `rsp_valid` pulse in the next cycle. A matching tag never faults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Load check mode and clear flag |
| cfg_mode | input | 2 | Check mode: 00 off, 01 sync, 10 async, 11 asymmetric |
| flag_clr | input | 1 | Clear the sticky asynchronous fault flag |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | High when no fill is running |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | 64 | Tagged pointer |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after accept |
| rsp_rdata | output | 32 | Read data, 0 on fault or for writes |
| rsp_fault | output | 1 | Synchronous tag fault strobe |
| rsp_status | output | 6 | Fault status code, 6'b010001 on fault else 0 |
| rsp_fnv | output | 1 | Fault address not valid, always 0 |
| tag_flag | output | 1 | Sticky asynchronous fault flag |
| tcmd_valid | input | 1 | Start a tag fill (taken when idle) |
| tcmd_addr | input | 64 | Fill start pointer, top byte ignored |
| tcmd_len | input | 11 | Fill length in bytes |
| tcmd_tag | input | 4 | Tag value to write |

## Verification
The bench first drives every mode with matching pointers, mismatching pointers and pointers whose unused upper bits are random. This separates the tag compare from plain address decoding. Reads and writes are both tried in each mode, and blocked writes are read back later, so that suppression can be told apart from completion. Fills with unaligned ends, zero length and a range ending at the top of memory check the rounding and the per-granule cycle count. A seeded random mix of accesses, fills, clears and mode changes is then checked against a bench model of the data memory, the tags and the flag.

// File: rtl/mtag_pkg.sv
package mtag_pkg;
  typedef enum logic [1:0] {
    CHK_OFF   = 2'b00,
    CHK_SYNC  = 2'b01,
    CHK_ASYNC = 2'b10,
    CHK_ASYM  = 2'b11
  } chk_mode_e;

  localparam logic [5:0] TAG_FAULT_CODE = 6'b010001;
endpackage

// File: rtl/mtag_policy.sv
module mtag_policy
  import mtag_pkg::*;
#(
  parameter int TAG_W = 4
) (
  input  chk_mode_e        mode,
  input  logic             active,
  input  logic             is_write,
  input  logic [TAG_W-1:0] ltag,
  input  logic [TAG_W-1:0] atag,
  output logic             sync_fault,
  output logic             async_hit
);
  logic mism;
  logic sync_dir;
  logic async_dir;

  always_comb begin
    mism      = active && (ltag != atag);
    sync_dir  = (mode == CHK_SYNC) || (mode == CHK_ASYM && !is_write);
    async_dir = (mode == CHK_ASYNC) || (mode == CHK_ASYM && is_write);
    sync_fault = mism && sync_dir;
    async_hit  = mism && async_dir;
  end
endmodule

// File: rtl/mtag_store.sv
module mtag_store #(
  parameter int MEM_AW    = 10,
  parameter int GRAN_LOG2 = 4,
  parameter int TAG_W     = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         cmd_valid,
  input  logic [MEM_AW-1:0]            cmd_addr,
  input  logic [MEM_AW:0]              cmd_len,
  input  logic [TAG_W-1:0]             cmd_tag,
  input  logic [MEM_AW-GRAN_LOG2-1:0]  rd_idx,
  output logic [TAG_W-1:0]             rd_tag,
  output logic                         busy
);
  localparam int GI_W   = MEM_AW - GRAN_LOG2;
  localparam int NGRAN  = 1 << GI_W;
  localparam int CNT_W  = GI_W + 2;
  localparam int SUM_W  = MEM_AW + 2;

  logic [TAG_W-1:0] tags [NGRAN];
  logic [CNT_W-1:0] cur_q, last_q;
  logic [TAG_W-1:0] fill_tag_q;
  logic [SUM_W-1:0] end_sum;
  logic [CNT_W-1:0] start_g, end_g;

  always_comb begin
    end_sum = SUM_W'(cmd_addr) + SUM_W'(cmd_len) + SUM_W'((1 << GRAN_LOG2) - 1);
    end_g   = end_sum[SUM_W-1:GRAN_LOG2];
    start_g = CNT_W'(cmd_addr[MEM_AW-1:GRAN_LOG2]);
  end

  assign busy   = (cur_q != last_q);
  assign rd_tag = tags[rd_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NGRAN; i++) tags[i] <= '0;
      cur_q      <= '0;
      last_q     <= '0;
      fill_tag_q <= '0;
    end else if (busy) begin
      tags[cur_q[GI_W-1:0]] <= fill_tag_q;
      cur_q <= cur_q + 1'b1;
    end else if (cmd_valid) begin
      cur_q      <= start_g;
      last_q     <= end_g;
      fill_tag_q <= cmd_tag;
    end
  end

  // R9: one granule advanced per busy cycle
  a_r9_one_per_cycle: assert property (@(posedge clk) disable iff (rst)
    busy |=> (cur_q == $past(cur_q) + 1'b1));
  // R9: the range end never moves during a fill
  a_r9_end_stable: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(last_q));
endmodule

// File: rtl/mtag_data_ram.sv
module mtag_data_ram #(
  parameter int AW     = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);
  logic [DATA_W-1:0] mem [1 << AW];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    q <= mem[addr];
  end
endmodule

// File: rtl/mem_tag_guard.sv
module mem_tag_guard
  import mtag_pkg::*;
#(
  parameter int ADDR_W    = 64,
  parameter int DATA_W    = 32,
  parameter int MEM_AW    = 10,
  parameter int GRAN_LOG2 = 4,
  parameter int TAG_W     = 4,
  parameter int TAG_LSB   = 56
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_mode,
  input  logic              flag_clr,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_fault,
  output logic [5:0]        rsp_status,
  output logic              rsp_fnv,
  output logic              tag_flag,
  input  logic              tcmd_valid,
  input  logic [ADDR_W-1:0] tcmd_addr,
  input  logic [MEM_AW:0]   tcmd_len,
  input  logic [TAG_W-1:0]  tcmd_tag
);
  localparam int WORD_LOG2 = $clog2(DATA_W / 8);
  localparam int WORD_AW   = MEM_AW - WORD_LOG2;
  localparam int GI_W      = MEM_AW - GRAN_LOG2;

  chk_mode_e          mode_q;
  logic               fill_busy;
  logic               req_fire;
  logic [TAG_W-1:0]   ltag, atag;
  logic               sync_fault, async_hit;
  logic [DATA_W-1:0]  ram_q;
  logic               valid_q, fault_q, pass_q, flag_q;

  assign req_ready = !fill_busy;
  assign req_fire  = req_valid && !fill_busy;
  assign ltag      = req_addr[TAG_LSB +: TAG_W];

  mtag_store #(.MEM_AW(MEM_AW), .GRAN_LOG2(GRAN_LOG2), .TAG_W(TAG_W)) u_tags (
    .clk      (clk),
    .rst      (rst),
    .cmd_valid(tcmd_valid),
    .cmd_addr (tcmd_addr[MEM_AW-1:0]),
    .cmd_len  (tcmd_len),
    .cmd_tag  (tcmd_tag),
    .rd_idx   (req_addr[MEM_AW-1:GRAN_LOG2]),
    .rd_tag   (atag),
    .busy     (fill_busy)
  );

  mtag_policy #(.TAG_W(TAG_W)) u_policy (
    .mode      (mode_q),
    .active    (req_fire),
    .is_write  (req_write),
    .ltag      (ltag),
    .atag      (atag),
    .sync_fault(sync_fault),
    .async_hit (async_hit)
  );

  mtag_data_ram #(.AW(WORD_AW), .DATA_W(DATA_W)) u_ram (
    .clk  (clk),
    .we   (req_fire && req_write && !sync_fault),
    .addr (req_addr[MEM_AW-1:WORD_LOG2]),
    .wdata(req_wdata),
    .q    (ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= CHK_OFF;
      valid_q <= 1'b0;
      fault_q <= 1'b0;
      pass_q  <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      if (cfg_we) mode_q <= chk_mode_e'(cfg_mode);
      valid_q <= req_fire;
      fault_q <= sync_fault;
      pass_q  <= req_fire && !req_write && !sync_fault;
      flag_q  <= (flag_q && !(cfg_we || flag_clr)) || async_hit;
    end
  end

  assign rsp_valid  = valid_q;
  assign rsp_fault  = fault_q;
  assign rsp_status = fault_q ? TAG_FAULT_CODE : 6'b0;
  assign rsp_fnv    = 1'b0;
  assign rsp_rdata  = pass_q ? ram_q : '0;
  assign tag_flag   = flag_q;

  // R10: one response per accepted request, one cycle later
  a_r10_rsp_follows: assert property (@(posedge clk) disable iff (rst)
    req_fire |=> rsp_valid);
  a_r10_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !req_fire |=> !rsp_valid);
  // R2: checking off never faults
  a_r2_off_no_fault: assert property (@(posedge clk) disable iff (rst)
    (mode_q == CHK_OFF && req_fire) |=> !rsp_fault);
  // R4: a synchronous fault never raises the flag
  a_r4_sync_no_flag: assert property (@(posedge clk) disable iff (rst)
    (rsp_fault && !$past(tag_flag)) |-> !tag_flag);
  // R7: flag is sticky without a clear
  a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
    (tag_flag && !cfg_we && !flag_clr) |=> tag_flag);
  // R8: mode write clears the flag when no access races it
  a_r8_mode_clears: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && !req_valid) |=> !tag_flag);
endmodule

// File: tb/tb_mem_tag_guard.sv
module tb_mem_tag_guard;
  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_we = 0;
  logic [1:0]  cfg_mode = 0;
  logic        flag_clr = 0;
  logic        req_valid = 0;
  logic        req_ready;
  logic        req_write = 0;
  logic [63:0] req_addr = 0;
  logic [31:0] req_wdata = 0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        rsp_fault;
  logic [5:0]  rsp_status;
  logic        rsp_fnv;
  logic        tag_flag;
  logic        tcmd_valid = 0;
  logic [63:0] tcmd_addr = 0;
  logic [10:0] tcmd_len = 0;
  logic [3:0]  tcmd_tag = 0;

  int n_chk = 0;
  int n_err = 0;
  logic [3:0]  tag_m [64];
  logic [31:0] mem_m [256];
  logic [1:0]  mode_m = 0;
  bit          flag_m = 0;

  always #10 clk = ~clk;

  mem_tag_guard dut (.*);

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mkptr(input logic [3:0] t, input logic [9:0] phys);
    logic [63:0] p;
    p = {$urandom, $urandom};
    p[59:56] = t;
    p[9:0]   = phys;
    return p;
  endfunction

  function automatic bit sync_of(input logic [1:0] m, input bit w);
    return (m == 2'b01) || (m == 2'b11 && !w);
  endfunction

  function automatic bit async_of(input logic [1:0] m, input bit w);
    return (m == 2'b10) || (m == 2'b11 && w);
  endfunction

  task automatic access(input bit w, input logic [63:0] a, input logic [31:0] d, input string req);
    bit mism, sf, ah;
    logic [31:0] exp_rd;
    @(negedge clk);
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
    mism = (a[59:56] != tag_m[a[9:4]]);
    sf = mism && sync_of(mode_m, w);
    ah = mism && async_of(mode_m, w);
    exp_rd = (w || sf) ? 32'h0 : mem_m[a[9:2]];
    check(rsp_valid == 1'b1, {req, " R10 rsp_valid"}, 64'(rsp_valid), 1);
    check(rsp_fault == sf, {req, " fault"}, 64'(rsp_fault), 64'(sf));
    check(rsp_status == (sf ? 6'b010001 : 6'b0), {req, " R4 status"}, 64'(rsp_status), sf ? 64'h11 : 0);
    check(rsp_fnv == 1'b0, {req, " R4 fnv"}, 64'(rsp_fnv), 0);
    check(rsp_rdata == exp_rd, {req, " rdata"}, 64'(rsp_rdata), 64'(exp_rd));
    if (w && !sf) mem_m[a[9:2]] = d;
    if (ah) flag_m = 1;
    check(tag_flag == flag_m, {req, " flag"}, 64'(tag_flag), 64'(flag_m));
  endtask

  task automatic set_mode(input logic [1:0] m);
    @(negedge clk);
    cfg_we = 1; cfg_mode = m;
    @(negedge clk);
    cfg_we = 0;
    mode_m = m; flag_m = 0;
    check(tag_flag == 1'b0, "R8 mode write clears flag", 64'(tag_flag), 0);
  endtask

  task automatic clear_flag();
    @(negedge clk);
    flag_clr = 1;
    @(negedge clk);
    flag_clr = 0;
    flag_m = 0;
    check(tag_flag == 1'b0, "R7 clear", 64'(tag_flag), 0);
  endtask

  task automatic fill(input logic [9:0] start, input int len, input logic [3:0] t);
    int first, last, n;
    first = start / 16;
    last  = (start + len + 15) / 16;
    @(negedge clk);
    tcmd_valid = 1; tcmd_addr = mkptr(4'($urandom), start); tcmd_len = 11'(len); tcmd_tag = t;
    @(negedge clk);
    tcmd_valid = 0;
    n = 0;
    while (!req_ready && n < 100) begin
      n++;
      @(negedge clk);
    end
    check(n == last - first, "R9 fill cycle count", 64'(n), 64'(last - first));
    for (int g = first; g < last; g++) tag_m[g] = t;
  endtask

  initial begin
    #(20 * 150000);
    n_err++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    for (int i = 0; i < 64; i++) tag_m[i] = 0;
    rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R1 reset state
    check(rsp_valid == 0, "R1 rsp_valid", 64'(rsp_valid), 0);
    check(rsp_fault == 0, "R1 rsp_fault", 64'(rsp_fault), 0);
    check(tag_flag == 0, "R1 flag", 64'(tag_flag), 0);
    check(req_ready == 1, "R1 req_ready", 64'(req_ready), 1);

    // R2: mode 00 preload with random tags (R3 random upper bits)
    for (int i = 0; i < 256; i++) access(1, mkptr(4'($urandom), 10'(i * 4)), $urandom, "R2 preload");
    for (int i = 0; i < 8; i++) access(0, mkptr(4'($urandom), 10'($urandom)), 0, "R2 off read");
    // R1: all tags are zero after reset
    set_mode(2'b01);
    for (int g = 0; g < 64; g += 9) access(0, mkptr(4'h0, 10'(g * 16 + 5)), 0, "R1 zero tags");

    // R9 fills
    fill(10'h023, 'h40, 4'h5);
    fill(10'h100, 0, 4'h9);
    fill(10'h3F8, 8, 4'hA);
    fill(10'h200, 1, 4'h7);

    // R4/R6 synchronous
    access(0, mkptr(4'h5, 10'h034), 0, "R10 sync match read");
    access(0, mkptr(4'h3, 10'h034), 0, "R4 sync mismatch read");
    access(1, mkptr(4'h3, 10'h060), 32'hDEADBEEF, "R4 sync blocked write");
    access(0, mkptr(4'h5, 10'h060), 0, "R4 blocked write readback");
    access(0, mkptr(4'h0, 10'h100), 0, "R9 zero-length fill left tag");
    access(0, mkptr(4'hA, 10'h3FC), 0, "R9 top granule");
    access(0, mkptr(4'h5, 10'h06F), 0, "R3 byte offset in granule");

    // R5 async
    set_mode(2'b10);
    access(0, mkptr(4'h1, 10'h040), 0, "R5 async read");
    access(0, mkptr(4'h5, 10'h044), 0, "R7 flag sticky");
    access(1, mkptr(4'h1, 10'h048), 32'h12345678, "R5 async write");
    access(0, mkptr(4'h5, 10'h048), 0, "R5 write committed");
    clear_flag();

    // R6 asymmetric
    set_mode(2'b11);
    access(0, mkptr(4'h2, 10'h050), 0, "R6 asym read");
    access(1, mkptr(4'h2, 10'h050), 32'hCAFEF00D, "R6 asym write");
    access(0, mkptr(4'h5, 10'h050), 0, "R6 readback");
    set_mode(2'b11);

    // random mix
    for (int i = 0; i < 600; i++) begin
      int r;
      logic [9:0] pa;
      r = $urandom_range(0, 99);
      pa = 10'($urandom);
      if (r < 4) set_mode(2'($urandom));
      else if (r < 7) clear_flag();
      else if (r < 10) begin
        int s, l;
        s = $urandom_range(0, 1000);
        l = $urandom_range(0, 1024 - s);
        if (l > 96) l = $urandom_range(0, 96);
        fill(10'(s), l, 4'($urandom));
      end else begin
        logic [3:0] t;
        t = ($urandom_range(0, 1) == 1) ? tag_m[pa[9:4]] : 4'($urandom);
        access(r[0], mkptr(t, pa), $urandom, "R6 random access");
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule